// File: doc/BRIEF.md
# DDR Serial Memory Host Sequencer

This block is the host side of an 8-bit double-data-rate serial memory link. It takes one burst request at a time (read or write, starting word address, length in 16-bit words). It then drives chip select, the bus clock and the byte-wide data lane through each phase of a transaction. These phases are a three-clock command/address phase, an initial latency period, and a data phase. The data strobe line RWDS serves three purposes: it tells the host to wait longer, it masks write bytes, and it strobes read data.

The block runs on an internal clock at twice the bus clock rate. One internal cycle carries one bus clock edge and therefore one byte. The bus clock output toggles on every internal cycle while chip select is low. Chip-select-low time is limited by a run-time budget, `cfg_cs_max`, counted in internal cycles, so that the memory can refresh itself between transactions. A burst that does not fit in one transaction is cut at a word boundary. Chip select is then held high for a fixed gap, and a new transaction continues at the next word address with the words that remain. Pad cells, clock phase shifting and board timing are handled outside the block.

Top module: `ddrseq`

## Requirements
- R1: After reset, `bus_cs_n` is high, `bus_ck` is low, `bus_dq_oe` and `bus_rwds_oe` are low, and `req_ready` is high.
- R2: Each transaction begins with six internal cycles of command/address, one byte per cycle, taken from a 48-bit word starting with bits 47:40. The fields of that word are: bit 47 is 1 for a read and 0 for a write, bit 46 is 0 (memory space), bit 45 is 1 (linear burst), the low `AW` bits hold the word address, and all other bits are 0.
- R3: After the command/address phase, the latency period lasts 2*`cfg_latency` internal cycles if `bus_rwds_in` was low in all six command/address cycles. It lasts 4*`cfg_latency` cycles if `bus_rwds_in` was high in any of them.
- R4: A write word takes two internal cycles. `wr_data[15:8]` is sent first and `wr_data[7:0]` second. `wr_ready` is high in the cycle whose closing clock edge takes the word.
- R5: During write data, `bus_rwds_out` carries the inverted byte enable. `wr_be[1]` covers the first byte and `wr_be[0]` covers the second. A high strobe masks the byte, so the memory leaves that byte unchanged.
- R6: During read data the host drives neither DQ nor RWDS. A byte is captured in each cycle in which `bus_rwds_in` differs from its value in the previous cycle. The first byte of each pair goes to `rd_data[15:8]`, and `rd_valid` pulses once per word.
- R7: Chip select never stays low longer than `cfg_cs_max` internal cycles. Each transaction carries min(remaining, floor((`cfg_cs_max` - 6 - latency) / 2)) words.
- R8: A split burst continues with a new transaction at the word address after the last word moved, with the remaining length, until all requested words have moved.
- R9: Between the transactions of one split burst, chip select stays high for exactly `CSH` internal cycles.
- R10: While chip select is low, `bus_ck` is high in the first cycle and inverts on every following cycle. While chip select is high, `bus_ck` is low.
- R11: `req_ready` is high only while idle. `done` pulses for one cycle after the closing gap of the last transaction of a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_latency | input | LATW | Base initial latency in bus clocks |
| cfg_cs_max | input | CW | Chip-select-low budget in internal cycles |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | AW | Starting word address |
| req_len | input | LW | Burst length in words, nonzero |
| wr_data | input | 16 | Write word, high byte sent first |
| wr_be | input | 2 | Byte enables for write word |
| wr_ready | output | 1 | Write word taken at next edge |
| rd_data | output | 16 | Assembled read word |
| rd_valid | output | 1 | Read word valid |
| done | output | 1 | Request finished |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_ck | output | 1 | Bus clock |
| bus_dq_out | output | 8 | DQ value driven by host |
| bus_dq_oe | output | 1 | DQ output enable |
| bus_dq_in | input | 8 | DQ value from memory |
| bus_rwds_out | output | 1 | Strobe/mask driven by host |
| bus_rwds_oe | output | 1 | Strobe output enable |
| bus_rwds_in | input | 1 | Strobe from memory |

## Verification
The embedded properties assume several things about the inputs. An accepted request has a nonzero length and `cfg_latency` is nonzero. The memory leaves RWDS low for the whole latency period and toggles it exactly once per read byte. `cfg_latency` and `cfg_cs_max` stay stable while a request is open, and the budget leaves room for at least one word after the longest latency. Write data is valid whenever `wr_ready` is high. The stimulus respects these assumptions by construction. Configuration changes only between requests, the budgets are derived from 4*`cfg_latency`+6 plus slack, and the bench memory model derives its strobe timing from the same latency rule it checks.

// File: rtl/ddrseq_pkg.sv
package ddrseq_pkg;

  localparam int CA_BYTES = 6;
  localparam int CA_BITS  = 48;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CA,
    S_LAT,
    S_DATA,
    S_GAP
  } seq_state_t;

  function automatic logic [CA_BITS-1:0] make_ca(input logic is_read,
                                                 input logic [44:0] waddr);
    logic [CA_BITS-1:0] w;
    w       = '0;
    w[47]   = is_read;
    w[46]   = 1'b0;
    w[45]   = 1'b1;
    w[44:0] = waddr;
    return w;
  endfunction

endpackage

// File: rtl/ddrseq_plan.sv
module ddrseq_plan #(
  parameter int AW   = 20,
  parameter int LW   = 8,
  parameter int CW   = 12,
  parameter int LATW = 4
) (
  input  logic                          is_read,
  input  logic [AW-1:0]                 addr,
  input  logic [LW-1:0]                 left,
  input  logic [LATW-1:0]               cfg_latency,
  input  logic [CW-1:0]                 cfg_cs_max,
  input  logic                          extra,
  output logic [ddrseq_pkg::CA_BITS-1:0] ca_word,
  output logic [LATW+1:0]               lat_cycles,
  output logic [LW-1:0]                 part_words
);
  import ddrseq_pkg::*;

  localparam int BW = CW + 1;

  logic [BW-1:0] overhead;
  logic [BW-1:0] budget;
  logic [BW-1:0] cap;

  always_comb begin
    ca_word = make_ca(is_read, 45'(addr));
  end

  always_comb begin
    if (extra) lat_cycles = {cfg_latency, 2'b00};
    else       lat_cycles = {1'b0, cfg_latency, 1'b0};
  end

  always_comb begin
    overhead = BW'(CA_BYTES) + BW'(lat_cycles);
    budget   = {1'b0, cfg_cs_max};
    if (budget > overhead) cap = (budget - overhead) >> 1;
    else                   cap = '0;
    if (cap >= BW'(left)) part_words = left;
    else                  part_words = cap[LW-1:0];
  end

endmodule

// File: rtl/ddrseq_wr_lane.sv
module ddrseq_wr_lane (
  input  logic       clk,
  input  logic       rst_sn,
  input  logic       take,
  input  logic [15:0] wr_data,
  input  logic [1:0]  wr_be,
  output logic [7:0]  first_byte,
  output logic        first_mask,
  output logic [7:0]  second_byte,
  output logic        second_mask
);

  logic [7:0] byte_q, byte_d;
  logic       mask_q, mask_d;

  always_comb begin
    first_byte = wr_data[15:8];
    first_mask = ~wr_be[1];
    byte_d     = byte_q;
    mask_d     = mask_q;
    if (take) begin
      byte_d = wr_data[7:0];
      mask_d = ~wr_be[0];
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      byte_q <= '0;
      mask_q <= 1'b1;
    end else begin
      byte_q <= byte_d;
      mask_q <= mask_d;
    end
  end

  assign second_byte = byte_q;
  assign second_mask = mask_q;

endmodule

// File: rtl/ddrseq_rd_lane.sv
module ddrseq_rd_lane (
  input  logic        clk,
  input  logic        rst_sn,
  input  logic        en,
  input  logic        rwds_in,
  input  logic [7:0]  dq_in,
  output logic        word_take,
  output logic [15:0] rd_data,
  output logic        rd_valid
);

  logic        prev_q;
  logic        have_q, have_d;
  logic [7:0]  first_q, first_d;
  logic [15:0] data_q, data_d;
  logic        valid_d, valid_q;
  logic        strobe;

  always_comb begin
    strobe    = en && (rwds_in != prev_q);
    word_take = strobe && have_q;
    have_d    = have_q;
    first_d   = first_q;
    data_d    = data_q;
    valid_d   = 1'b0;
    if (!en) begin
      have_d = 1'b0;
    end else if (strobe) begin
      if (have_q) begin
        data_d  = {first_q, dq_in};
        valid_d = 1'b1;
        have_d  = 1'b0;
      end else begin
        first_d = dq_in;
        have_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      prev_q  <= 1'b0;
      have_q  <= 1'b0;
      first_q <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      prev_q  <= rwds_in;
      have_q  <= have_d;
      first_q <= first_d;
      data_q  <= data_d;
      valid_q <= valid_d;
    end
  end

  assign rd_data  = data_q;
  assign rd_valid = valid_q;

  // a word can only appear right after a cycle of read data capture
  p_valid_from_capture_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    rd_valid |-> $past(en));

endmodule

// File: rtl/ddrseq.sv
module ddrseq #(
  parameter int AW   = 20,
  parameter int LW   = 8,
  parameter int CW   = 12,
  parameter int LATW = 4,
  parameter int CSH  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LATW-1:0] cfg_latency,
  input  logic [CW-1:0]   cfg_cs_max,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [LW-1:0]   req_len,
  input  logic [15:0]     wr_data,
  input  logic [1:0]      wr_be,
  output logic            wr_ready,
  output logic [15:0]     rd_data,
  output logic            rd_valid,
  output logic            done,
  output logic            bus_cs_n,
  output logic            bus_ck,
  output logic [7:0]      bus_dq_out,
  output logic            bus_dq_oe,
  input  logic [7:0]      bus_dq_in,
  output logic            bus_rwds_out,
  output logic            bus_rwds_oe,
  input  logic            bus_rwds_in
);
  import ddrseq_pkg::*;

  localparam int LCW  = LATW + 2;
  localparam int GW   = $clog2(CSH + 1);
  localparam int CNTW = (LCW > GW) ? LCW : GW;
  localparam int HW   = GW + 1;

  // reset: asynchronous assert, synchronous release
  logic rs0_q, rs1_q, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs0_q <= 1'b0;
      rs1_q <= 1'b0;
    end else begin
      rs0_q <= 1'b1;
      rs1_q <= rs0_q;
    end
  end
  assign rst_sn = rs1_q;

  seq_state_t           st_q, st_d;
  logic [CNTW-1:0]      cnt_q, cnt_d;
  logic [AW-1:0]        addr_q, addr_d;
  logic [LW-1:0]        left_q, left_d;
  logic [LW-1:0]        part_q, part_d;
  logic                 wr_q, wr_d;
  logic                 extra_q, extra_d;
  logic                 half_q, half_d;
  logic                 cs_n_q, cs_n_d;
  logic                 ck_q, ck_d;
  logic [7:0]           dq_q, dq_d;
  logic                 dq_oe_q, dq_oe_d;
  logic                 rwds_q, rwds_d;
  logic                 rwds_oe_q, rwds_oe_d;
  logic [CA_BITS-1:0]   ca_sr_q, ca_sr_d;
  logic                 done_q, done_d;
  logic                 wr_take;

  // planner inputs select the request itself while idle
  logic                 idle;
  logic                 pl_read;
  logic [AW-1:0]        pl_addr;
  logic [LW-1:0]        pl_left;
  logic                 pl_extra;
  logic [CA_BITS-1:0]   ca_word;
  logic [LCW-1:0]       lat_cycles;
  logic [LW-1:0]        part_words;

  assign idle     = (st_q == S_IDLE);
  assign pl_read  = idle ? !req_write : !wr_q;
  assign pl_addr  = idle ? req_addr   : addr_q;
  assign pl_left  = idle ? req_len    : left_q;
  assign pl_extra = extra_q | bus_rwds_in;

  ddrseq_plan #(.AW(AW), .LW(LW), .CW(CW), .LATW(LATW)) u_plan (
    .is_read    (pl_read),
    .addr       (pl_addr),
    .left       (pl_left),
    .cfg_latency(cfg_latency),
    .cfg_cs_max (cfg_cs_max),
    .extra      (pl_extra),
    .ca_word    (ca_word),
    .lat_cycles (lat_cycles),
    .part_words (part_words)
  );

  logic [7:0] wl_first, wl_second;
  logic       wl_first_m, wl_second_m;

  ddrseq_wr_lane u_wr (
    .clk        (clk),
    .rst_sn     (rst_sn),
    .take       (wr_take),
    .wr_data    (wr_data),
    .wr_be      (wr_be),
    .first_byte (wl_first),
    .first_mask (wl_first_m),
    .second_byte(wl_second),
    .second_mask(wl_second_m)
  );

  logic rd_en, rd_word;

  assign rd_en = (st_q == S_DATA) && !wr_q;

  ddrseq_rd_lane u_rd (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .en       (rd_en),
    .rwds_in  (bus_rwds_in),
    .dq_in    (bus_dq_in),
    .word_take(rd_word),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  // next-state logic
  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    addr_d    = addr_q;
    left_d    = left_q;
    part_d    = part_q;
    wr_d      = wr_q;
    extra_d   = extra_q;
    half_d    = half_q;
    cs_n_d    = cs_n_q;
    ck_d      = ck_q;
    dq_d      = dq_q;
    dq_oe_d   = dq_oe_q;
    rwds_d    = rwds_q;
    rwds_oe_d = rwds_oe_q;
    ca_sr_d   = ca_sr_q;
    done_d    = 1'b0;
    wr_take   = 1'b0;

    unique case (st_q)
      S_IDLE: begin
        if (req_valid) begin
          addr_d  = req_addr;
          left_d  = req_len;
          wr_d    = req_write;
          cs_n_d  = 1'b0;
          ck_d    = 1'b1;
          dq_d    = ca_word[47:40];
          dq_oe_d = 1'b1;
          ca_sr_d = {ca_word[39:0], 8'h00};
          cnt_d   = CNTW'(CA_BYTES - 1);
          extra_d = 1'b0;
          st_d    = S_CA;
        end
      end

      S_CA: begin
        ck_d    = ~ck_q;
        extra_d = pl_extra;
        if (cnt_q != '0) begin
          dq_d    = ca_sr_q[47:40];
          ca_sr_d = {ca_sr_q[39:0], 8'h00};
          cnt_d   = cnt_q - 1'b1;
        end else begin
          dq_d    = '0;
          dq_oe_d = 1'b0;
          cnt_d   = CNTW'(lat_cycles) - 1'b1;
          part_d  = part_words;
          st_d    = S_LAT;
        end
      end

      S_LAT: begin
        ck_d = ~ck_q;
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else begin
          st_d   = S_DATA;
          half_d = 1'b0;
          if (wr_q) begin
            wr_take   = 1'b1;
            dq_d      = wl_first;
            rwds_d    = wl_first_m;
            dq_oe_d   = 1'b1;
            rwds_oe_d = 1'b1;
          end
        end
      end

      S_DATA: begin
        ck_d = ~ck_q;
        if (wr_q && !half_q) begin
          dq_d   = wl_second;
          rwds_d = wl_second_m;
          half_d = 1'b1;
        end else if ((wr_q && half_q) || (!wr_q && rd_word)) begin
          half_d = 1'b0;
          addr_d = addr_q + 1'b1;
          left_d = left_q - 1'b1;
          part_d = part_q - 1'b1;
          if (part_q == LW'(1)) begin
            cs_n_d    = 1'b1;
            ck_d      = 1'b0;
            dq_d      = '0;
            dq_oe_d   = 1'b0;
            rwds_d    = 1'b0;
            rwds_oe_d = 1'b0;
            cnt_d     = CNTW'(CSH - 1);
            st_d      = S_GAP;
          end else if (wr_q) begin
            wr_take = 1'b1;
            dq_d    = wl_first;
            rwds_d  = wl_first_m;
          end
        end
      end

      S_GAP: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else if (left_q != '0) begin
          cs_n_d  = 1'b0;
          ck_d    = 1'b1;
          dq_d    = ca_word[47:40];
          dq_oe_d = 1'b1;
          ca_sr_d = {ca_word[39:0], 8'h00};
          cnt_d   = CNTW'(CA_BYTES - 1);
          extra_d = 1'b0;
          st_d    = S_CA;
        end else begin
          done_d = 1'b1;
          st_d   = S_IDLE;
        end
      end

      default: st_d = S_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q      <= S_IDLE;
      cnt_q     <= '0;
      addr_q    <= '0;
      left_q    <= '0;
      part_q    <= '0;
      wr_q      <= 1'b0;
      extra_q   <= 1'b0;
      half_q    <= 1'b0;
      cs_n_q    <= 1'b1;
      ck_q      <= 1'b0;
      dq_q      <= '0;
      dq_oe_q   <= 1'b0;
      rwds_q    <= 1'b0;
      rwds_oe_q <= 1'b0;
      ca_sr_q   <= '0;
      done_q    <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      addr_q    <= addr_d;
      left_q    <= left_d;
      part_q    <= part_d;
      wr_q      <= wr_d;
      extra_q   <= extra_d;
      half_q    <= half_d;
      cs_n_q    <= cs_n_d;
      ck_q      <= ck_d;
      dq_q      <= dq_d;
      dq_oe_q   <= dq_oe_d;
      rwds_q    <= rwds_d;
      rwds_oe_q <= rwds_oe_d;
      ca_sr_q   <= ca_sr_d;
      done_q    <= done_d;
    end
  end

  assign req_ready    = idle;
  assign wr_ready     = wr_take;
  assign done         = done_q;
  assign bus_cs_n     = cs_n_q;
  assign bus_ck       = ck_q;
  assign bus_dq_out   = dq_q;
  assign bus_dq_oe    = dq_oe_q;
  assign bus_rwds_out = rwds_q;
  assign bus_rwds_oe  = rwds_oe_q;

  // checker counters for chip-select run lengths
  logic [CW:0] chk_lo_q;
  logic [HW-1:0] chk_hi_q;
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      chk_lo_q <= '0;
      chk_hi_q <= '1;
    end else begin
      if (cs_n_q) chk_lo_q <= '0;
      else        chk_lo_q <= chk_lo_q + 1'b1;
      if (!cs_n_q)            chk_hi_q <= '0;
      else if (chk_hi_q != '1) chk_hi_q <= chk_hi_q + 1'b1;
    end
  end

  p_cs_budget_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    chk_lo_q <= {1'b0, cfg_cs_max});

  p_gap_len_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(cs_n_q) |-> (chk_hi_q >= HW'(CSH)));

  p_ck_toggle_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    (!cs_n_q && !$past(cs_n_q)) |-> (ck_q != $past(ck_q)));

  p_ck_parked_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    cs_n_q |-> !ck_q);

  p_read_hands_off_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == S_DATA && !wr_q) |-> (!dq_oe_q && !rwds_oe_q));

  p_req_legal_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    (req_valid && req_ready) |-> (req_len != '0 && cfg_latency != '0));

  p_done_after_gap_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    done_q |-> ($past(st_q) == S_GAP && cs_n_q));

endmodule

// File: tb/ddrseq_test.sv
module ddrseq_test;

  localparam int TCLK = 10;
  localparam int CSH  = 4;

  logic        clk;
  logic        rst_n;
  logic [3:0]  cfg_latency;
  logic [11:0] cfg_cs_max;
  logic        req_valid, req_ready, req_write;
  logic [19:0] req_addr;
  logic [7:0]  req_len;
  logic [15:0] wr_data;
  logic [1:0]  wr_be;
  logic        wr_ready;
  logic [15:0] rd_data;
  logic        rd_valid, done;
  logic        bus_cs_n, bus_ck, bus_dq_oe, bus_rwds_out, bus_rwds_oe;
  logic [7:0]  bus_dq_out, bus_dq_in;
  logic        bus_rwds_in;

  ddrseq #(.CSH(CSH)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_latency(cfg_latency), .cfg_cs_max(cfg_cs_max),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .wr_data(wr_data), .wr_be(wr_be),
    .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid), .done(done),
    .bus_cs_n(bus_cs_n), .bus_ck(bus_ck), .bus_dq_out(bus_dq_out), .bus_dq_oe(bus_dq_oe),
    .bus_dq_in(bus_dq_in), .bus_rwds_out(bus_rwds_out), .bus_rwds_oe(bus_rwds_oe),
    .bus_rwds_in(bus_rwds_in)
  );

  initial clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  int total = 0;
  int bad = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model, shadow and monitors
  logic [15:0] mem [64];
  logic [15:0] shadow [64];
  logic [15:0] wdat [8];
  logic [1:0]  wbe [8];
  int   busy = 0;
  int   cyc = 0;
  int   lat_c = 0;
  int   maddr = 0;
  logic [47:0] ca = '0;
  int   mon_rem = 0, mon_addr = 0, mon_parts = 0, hi_cnt = 0;
  bit   mon_rd = 0;
  int   widx = 0;
  bit   pend = 0;
  int   rd_base = 0, rd_cnt = 0;
  int   cycles = 0;
  bit   wd_fired = 0;

  always @(negedge clk) begin
    cycles++;
    // write data feed
    if (pend) begin widx++; pend = 0; end
    wr_data = wdat[widx % 8];
    wr_be   = wbe[widx % 8];
    if (wr_ready) pend = 1;
    // read words
    if (rd_valid) begin
      check(rd_data == shadow[(rd_base + rd_cnt) % 64], "R6 read word", rd_data,
            shadow[(rd_base + rd_cnt) % 64]);
      rd_cnt++;
    end
    if (!bus_cs_n) begin
      cyc++;
      check(bus_ck == cyc[0], "R10 clock while selected", bus_ck, cyc[0]);
      if (cyc == 1 && mon_parts > 0)
        check(hi_cnt == CSH, "R9 gap length", hi_cnt, CSH);
      if (cyc <= 6) begin
        ca = {ca[39:0], bus_dq_out};
        bus_rwds_in = (busy != 0);
        if (cyc == 6) begin
          lat_c = 2 * int'(cfg_latency) * (busy != 0 ? 2 : 1);
          maddr = int'(ca[19:0]) % 64;
          check(ca[47] == mon_rd, "R2 read/write bit", ca[47], mon_rd);
          check(ca[46:45] == 2'b01, "R2 space and burst bits", ca[46:45], 1);
          check(ca[44:0] == 45'(mon_addr), "R8 part address", int'(ca[19:0]), mon_addr);
        end
      end else if (cyc <= 6 + lat_c) begin
        bus_rwds_in = 1'b0;
      end else begin
        int k;
        int w;
        k = cyc - 7 - lat_c;
        w = (maddr + k / 2) % 64;
        if (mon_rd) begin
          bus_dq_in   = (k % 2 == 0) ? mem[w][15:8] : mem[w][7:0];
          bus_rwds_in = ~bus_rwds_in;
        end else if (!bus_rwds_out) begin
          if (k % 2 == 0) mem[w][15:8] = bus_dq_out;
          else            mem[w][7:0]  = bus_dq_out;
        end
      end
    end else begin
      check(bus_ck == 1'b0, "R10 clock parked", bus_ck, 0);
      if (cyc > 0) begin
        int cap;
        int wexp;
        cap  = (int'(cfg_cs_max) - 6 - lat_c) / 2;
        wexp = (mon_rem < cap) ? mon_rem : cap;
        check(cyc == 6 + lat_c + 2 * wexp, "R3 R7 selected length", cyc, 6 + lat_c + 2 * wexp);
        check(cyc <= int'(cfg_cs_max), "R7 budget", cyc, int'(cfg_cs_max));
        mon_rem  -= wexp;
        mon_addr += wexp;
        mon_parts++;
        hi_cnt = 1;
      end else begin
        hi_cnt++;
      end
      cyc = 0;
      bus_rwds_in = 1'b0;
    end
    if (cycles > 150000 && !wd_fired) begin
      wd_fired = 1;
      check(0, "watchdog", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run_req(input bit wr, input int addr, input int len);
    int t;
    mon_rd   = !wr;
    mon_rem  = len;
    mon_addr = addr;
    mon_parts = 0;
    rd_base  = addr;
    rd_cnt   = 0;
    widx     = 0;
    pend     = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = 20'(addr);
    req_len   = 8'(len);
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!done && t < 2000) begin
      @(negedge clk);
      t++;
    end
    check(done == 1'b1, "R11 done pulse", done, 1);
    @(negedge clk);
    check(req_ready == 1'b1 && done == 1'b0, "R11 ready after done", req_ready, 1);
    check(mon_rem == 0 && mon_addr == addr + len, "R8 all words moved", mon_rem, 0);
    if (!wr) check(rd_cnt == len, "R6 word count", rd_cnt, len);
  endtask

  initial begin
    int idx;
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_len = '0;
    cfg_latency = 4'd1; cfg_cs_max = 12'd300;
    bus_dq_in = '0; bus_rwds_in = 1'b0;
    wr_data = '0; wr_be = '0;
    for (int i = 0; i < 64; i++) begin
      mem[i]    = 16'(16'hA500 + i * 16'h0107);
      shadow[i] = mem[i];
    end
    for (int i = 0; i < 8; i++) begin wdat[i] = '0; wbe[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(bus_cs_n == 1'b1, "R1 cs idle", bus_cs_n, 1);
    check(bus_ck == 1'b0, "R1 ck idle", bus_ck, 0);
    check(bus_dq_oe == 1'b0 && bus_rwds_oe == 1'b0, "R1 drivers off", bus_dq_oe, 0);
    check(req_ready == 1'b1, "R1 ready", req_ready, 1);

    idx = 0;
    for (int lat = 1; lat <= 3; lat++) begin
      for (int b = 0; b < 2; b++) begin
        for (int mx = 0; mx < 2; mx++) begin
          for (int len = 1; len <= 5; len++) begin
            int base;
            idx++;
            base = (idx * 11) % 58;
            cfg_latency = 4'(lat);
            cfg_cs_max  = (mx == 0) ? 12'd300 : 12'(6 + 4 * lat + 4 + (idx % 2));
            busy = b;
            // R4 R5 write with a sweep of byte enables
            for (int i = 0; i < len; i++) begin
              wdat[i] = 16'(idx * 16'h0123 + i * 16'h1111 + 16'h0F0F);
              wbe[i]  = 2'((idx + i) % 4);
              if (wbe[i][1]) shadow[base + i][15:8] = wdat[i][15:8];
              if (wbe[i][0]) shadow[base + i][7:0]  = wdat[i][7:0];
            end
            run_req(1'b1, base, len);
            for (int i = 0; i < len; i++)
              check(mem[base + i] == shadow[base + i], "R4 R5 stored word",
                    mem[base + i], shadow[base + i]);
            run_req(1'b0, base, len);
          end
        end
      end
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule